// File: doc/BRIEF.md
# Byte Bit-Reverse and Align Unit

This unit is an execution-stage datapath slice for a 64-bit RISC core. It takes two source operands, `in_rs` and `in_rt`, together with a sub-operation field, and produces the value to be written to the destination register. Two shuffle families are provided. The first reverses the bit order inside every byte while leaving the bytes where they are. The second joins two operands at a byte boundary, like a funnel shifter: the bytes of `in_rt` move up and are filled from the top bytes of `in_rs`. Each family comes in a word (32-bit, sign-extended) form and a doubleword (64-bit) form.

The core's decoder sends the unit an operand-width group bit (`in_wide`) and the 5-bit shift-amount field of the instruction (`in_sa`). The unit decodes the sub-operation from this field and takes the byte position from its low bits. Encodings that share the function group but are not implemented here, such as byte swaps and sign-extends, are reported on `out_illegal` so that the core can raise a trap. The result is registered, so it arrives one clock after the request, with `out_valid` set.

Top module: `byte_shuffle_unit`

## Requirements
- R1: While `rst` is high, and on the first clock after it is released, `out_valid`, `out_illegal` and `out_data` are all zero.
- R2: Each request with `in_valid` high produces exactly one result, one clock later, with `out_valid` high. A cycle with `in_valid` low produces `out_valid` low, `out_data` zero and `out_illegal` low on the next clock.
- R3: Word bit-reverse (`in_wide`=0, `in_sa`=5'b00000): for each byte k in 0..3 of `in_rt[31:0]`, the result bit 8k+i equals `in_rt` bit 8k+7-i. Bits 63:32 of the result are copies of result bit 31.
- R4: Doubleword bit-reverse (`in_wide`=1, `in_sa`=5'b00000): the same in-byte reversal is applied to all 8 bytes of `in_rt`, with no extension.
- R5: Word align (`in_wide`=0, `in_sa[4:2]`=3'b010, byte position p=`in_sa[1:0]`, p nonzero): the low 32 bits equal `(rt32 << 8p) | (rs32 >> 8(4-p))` on the 32-bit halves `in_rt[31:0]` and `in_rs[31:0]`. Bits 63:32 of the result copy bit 31.
- R6: Word align with p=0 (`in_sa`=5'b01000) returns `in_rt[31:0]` sign-extended to 64 bits.
- R7: Doubleword align (`in_wide`=1, `in_sa[4:3]`=2'b01, p=`in_sa[2:0]`, p nonzero): the result equals `(in_rt << 8p) | (in_rs >> 8(8-p))` on the full 64 bits.
- R8: Doubleword align with p=0 (`in_sa`=5'b01000) returns `in_rt` unchanged.
- R9: Every other (`in_wide`, `in_sa`) combination is illegal and gives `out_illegal`=1 with `out_data`=0. This includes the byte-swap and sign-extend codes 5'b00010, 5'b10000 and 5'b11000 in either group.
- R10: The word forms ignore `in_rs[63:32]` and `in_rt[63:32]`. Changing those bits does not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A request is present this cycle |
| in_wide | input | 1 | 0 selects the word group, 1 selects the doubleword group |
| in_sa | input | SA_W (5) | Sub-operation field; its low bits carry the byte position for align |
| in_rs | input | DATA_W (64) | First source operand; supplies the fill bytes for align |
| in_rt | input | DATA_W (64) | Second source operand; the shuffled operand |
| out_valid | output | 1 | Registered result is present |
| out_data | output | DATA_W (64) | Registered result; zero when idle or illegal |
| out_illegal | output | 1 | Registered flag for an unimplemented sub-operation |

## Verification
The case hardest to reach from the ports is the border between legal and illegal codes inside one field. Align is recognised only on the upper bits of `in_sa`, while bit-reverse is recognised on the whole field, so a decoder with one bit off still accepts most codes. The stimulus therefore sweeps all 64 combinations of `in_wide` and `in_sa` with fresh random operands on every code. It also sends word requests twice, with different upper halves, to show that those halves have no effect. Bursts of back-to-back requests are mixed with idle gaps so that the scoreboard also sees the valid bit and the zeroed idle output change between adjacent cycles.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  localparam int BYTE_W      = 8;
  localparam int SWAP_CODE   = 0;  // full-field match for bit reverse
  localparam int ALIGN_W_TAG = 2;  // upper field bits for word align
  localparam int ALIGN_D_TAG = 1;  // upper field bits for doubleword align

  typedef enum logic [2:0] {
    OP_BAD     = 3'd0,
    OP_SWAP_W  = 3'd1,
    OP_SWAP_D  = 3'd2,
    OP_ALIGN_W = 3'd3,
    OP_ALIGN_D = 3'd4
  } shuf_op_e;
endpackage

// File: rtl/bsu_decode.sv
module bsu_decode
  import bsu_pkg::*;
#(
  parameter int SA_W  = 5,
  parameter int BPW_W = 2,
  parameter int BPD_W = 3
) (
  input  logic             wide,
  input  logic [SA_W-1:0]  sa,
  output shuf_op_e         op,
  output logic [BPW_W-1:0] bp_w,
  output logic [BPD_W-1:0] bp_d
);
  localparam int TAGW_W = SA_W - BPW_W;
  localparam int TAGD_W = SA_W - BPD_W;

  always_comb begin
    bp_w = sa[BPW_W-1:0];
    bp_d = sa[BPD_W-1:0];
    op   = OP_BAD;
    if (sa == SA_W'(SWAP_CODE)) begin
      op = wide ? OP_SWAP_D : OP_SWAP_W;
    end else if (!wide && sa[SA_W-1:BPW_W] == TAGW_W'(ALIGN_W_TAG)) begin
      op = OP_ALIGN_W;
    end else if (wide && sa[SA_W-1:BPD_W] == TAGD_W'(ALIGN_D_TAG)) begin
      op = OP_ALIGN_D;
    end
  end
endmodule

// File: rtl/bsu_byte_rev.sv
module bsu_byte_rev #(
  parameter int W    = 64,
  parameter int BYTE = 8
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int NB = W / BYTE;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    for (genvar i = 0; i < BYTE; i++) begin : g_bit
      assign dout[g*BYTE + i] = din[g*BYTE + BYTE - 1 - i];
    end
  end
endmodule

// File: rtl/bsu_funnel.sv
module bsu_funnel #(
  parameter int W    = 64,
  parameter int BYTE = 8,
  parameter int BP_W = 3
) (
  input  logic [W-1:0]    hi,
  input  logic [W-1:0]    lo,
  input  logic [BP_W-1:0] bp,
  output logic [W-1:0]    dout
);
  localparam int SH_W = $clog2(W) + 1;

  logic [2*W-1:0]  cat;
  logic [SH_W-1:0] sh;

  // Shifting {hi,lo} right by W-8p leaves hi<<8p filled from lo's top bytes;
  // p=0 gives a shift of W and returns hi unchanged.
  assign cat  = {hi, lo};
  assign sh   = SH_W'(W) - SH_W'(BYTE * int'(bp));
  assign dout = W'(cat >> sh);
endmodule

// File: rtl/byte_shuffle_unit.sv
module byte_shuffle_unit
  import bsu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SA_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_wide,
  input  logic [SA_W-1:0]   in_sa,
  input  logic [DATA_W-1:0] in_rs,
  input  logic [DATA_W-1:0] in_rt,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_illegal
);
  localparam int HALF_W = DATA_W / 2;
  localparam int BPW_W  = $clog2(HALF_W / BYTE_W);
  localparam int BPD_W  = $clog2(DATA_W / BYTE_W);

  shuf_op_e          op;
  logic [BPW_W-1:0]  bp_w;
  logic [BPD_W-1:0]  bp_d;
  logic [DATA_W-1:0] rev;
  logic [HALF_W-1:0] al_w;
  logic [DATA_W-1:0] al_d;
  logic [DATA_W-1:0] res_c;

  bsu_decode #(.SA_W(SA_W), .BPW_W(BPW_W), .BPD_W(BPD_W)) u_dec (
    .wide(in_wide), .sa(in_sa), .op(op), .bp_w(bp_w), .bp_d(bp_d)
  );

  // One reverser serves both widths: the word form is its low half.
  bsu_byte_rev #(.W(DATA_W), .BYTE(BYTE_W)) u_rev (
    .din(in_rt), .dout(rev)
  );

  bsu_funnel #(.W(HALF_W), .BYTE(BYTE_W), .BP_W(BPW_W)) u_fun_w (
    .hi(in_rt[HALF_W-1:0]), .lo(in_rs[HALF_W-1:0]), .bp(bp_w), .dout(al_w)
  );

  bsu_funnel #(.W(DATA_W), .BYTE(BYTE_W), .BP_W(BPD_W)) u_fun_d (
    .hi(in_rt), .lo(in_rs), .bp(bp_d), .dout(al_d)
  );

  always_comb begin
    case (op)
      OP_SWAP_W:  res_c = {{HALF_W{rev[HALF_W-1]}}, rev[HALF_W-1:0]};
      OP_SWAP_D:  res_c = rev;
      OP_ALIGN_W: res_c = {{HALF_W{al_w[HALF_W-1]}}, al_w};
      OP_ALIGN_D: res_c = al_d;
      default:    res_c = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_data    <= '0;
    end else begin
      out_valid   <= in_valid;
      out_illegal <= in_valid && (op == OP_BAD);
      out_data    <= in_valid ? res_c : '0;
    end
  end

  // R2: a request yields a result on the next clock
  assert_req_to_valid_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2: an idle cycle yields a clean idle output
  assert_idle_clean_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && out_data == '0 && !out_illegal));

  // R9: illegal results carry zero data and are always valid
  assert_illegal_zero_R9: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> (out_valid && out_data == '0));

  // R3: word bit reverse is sign-extended
  assert_swap_w_sext_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_SWAP_W) |=>
      out_data[DATA_W-1:HALF_W] == {HALF_W{out_data[HALF_W-1]}});

  // R5: word align is sign-extended
  assert_align_w_sext_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_ALIGN_W) |=>
      out_data[DATA_W-1:HALF_W] == {HALF_W{out_data[HALF_W-1]}});

  // R8: doubleword align at byte position zero passes rt through
  assert_align_d_bp0_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_ALIGN_D && bp_d == '0) |=> out_data == $past(in_rt));
endmodule

// File: tb/byte_shuffle_unit_tb.sv
`timescale 1ns/1ps
module byte_shuffle_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_wide = 1'b0;
  logic [4:0]  in_sa = '0;
  logic [63:0] in_rs = '0;
  logic [63:0] in_rt = '0;
  logic        out_valid;
  logic [63:0] out_data;
  logic        out_illegal;

  int checks = 0;
  int fails  = 0;
  bit mon_on = 1'b0;
  bit done   = 1'b0;

  logic [63:0] q_data[$];
  logic        q_ill[$];
  string       q_tag[$];

  always #2 clk = ~clk;  // 250 MHz

  byte_shuffle_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_wide(in_wide),
    .in_sa(in_sa), .in_rs(in_rs), .in_rt(in_rt),
    .out_valid(out_valid), .out_data(out_data), .out_illegal(out_illegal)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] sext32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] ref_model(input logic wide, input logic [4:0] sa,
                                            input logic [63:0] rs, input logic [63:0] rt,
                                            output logic ill, output string tag);
    logic [63:0] rv;
    logic [31:0] w;
    int p;
    for (int b = 0; b < 8; b++)
      for (int i = 0; i < 8; i++)
        rv[b*8+i] = rt[b*8+7-i];
    ill = 1'b0;
    if (sa == 5'd0 && !wide) begin
      tag = "R3"; return sext32(rv[31:0]);
    end
    if (sa == 5'd0 && wide) begin
      tag = "R4"; return rv;
    end
    if (!wide && sa[4:2] == 3'b010) begin
      p = int'(sa[1:0]);
      if (p == 0) begin tag = "R6"; return sext32(rt[31:0]); end
      w = (rt[31:0] << (8*p)) | (rs[31:0] >> (8*(4-p)));
      tag = "R5"; return sext32(w);
    end
    if (wide && sa[4:3] == 2'b01) begin
      p = int'(sa[2:0]);
      if (p == 0) begin tag = "R8"; return rt; end
      tag = "R7"; return (rt << (8*p)) | (rs >> (8*(8-p)));
    end
    ill = 1'b1; tag = "R9";
    return 64'd0;
  endfunction

  task automatic send(input logic wide, input logic [4:0] sa,
                      input logic [63:0] rs, input logic [63:0] rt, input string force_tag);
    logic ill;
    string tag;
    logic [63:0] e;
    @(negedge clk);
    in_valid = 1'b1; in_wide = wide; in_sa = sa; in_rs = rs; in_rt = rt;
    e = ref_model(wide, sa, rs, rt, ill, tag);
    if (force_tag != "") tag = force_tag;
    q_data.push_back(e);
    q_ill.push_back(ill);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_wide  = 1'($urandom);
      in_sa    = 5'($urandom);
      in_rs    = {$urandom, $urandom};
      in_rt    = {$urandom, $urandom};
    end
  endtask

  // Monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (q_data.size() == 0) begin
          check(1'b0, "R2 unexpected valid", {1'b1, out_data}, 65'd0);
        end else begin
          logic [63:0] ed;
          logic        ei;
          string       et;
          ed = q_data.pop_front();
          ei = q_ill.pop_front();
          et = q_tag.pop_front();
          check(out_data == ed && out_illegal == ei, et,
                {out_illegal, out_data}, {ei, ed});
        end
      end else begin
        check(out_data == 64'd0 && !out_illegal, "R2 idle output",
              {out_illegal, out_data}, 65'd0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset holds outputs low even with a request present
    in_valid = 1'b1; in_sa = 5'd0; in_rt = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (3) @(negedge clk);
    check(!out_valid && !out_illegal && out_data == 64'd0, "R1 in reset",
          {out_illegal, out_data}, 65'd0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check(!out_valid && !out_illegal && out_data == 64'd0, "R1 after release",
          {out_illegal, out_data}, 65'd0);
    mon_on = 1'b1;

    // R3: word bit reverse, positive and negative sign cases
    send(1'b0, 5'd0, 64'h0, 64'h0123_4567_89AB_CDEF, "R3");
    send(1'b0, 5'd0, 64'h0, 64'h0000_0000_0100_0000, "R3");
    send(1'b0, 5'd0, 64'h0, 64'hFFFF_FFFF_FEFF_FFFF, "R3");
    // R4: doubleword bit reverse
    send(1'b1, 5'd0, 64'h0, 64'h0123_4567_89AB_CDEF, "R4");
    send(1'b1, 5'd0, 64'h0, 64'h8000_0000_0000_0001, "R4");
    idle(2);
    // R5, R6: word align at each byte position, rs upper half nonzero
    for (int p = 0; p < 4; p++)
      send(1'b0, 5'(8 + p), 64'hDEAD_BEEF_8899_AABB, 64'h5555_6666_1122_3344, "");
    // R7, R8: doubleword align at each byte position
    for (int p = 0; p < 8; p++)
      send(1'b1, 5'(8 + p), 64'h0011_2233_4455_6677, 64'h8899_AABB_CCDD_EEFF, "");
    idle(1);
    // R9: byte-swap and sign-extend codes in both groups
    send(1'b0, 5'b00010, 64'h1, 64'h2, "R9");
    send(1'b0, 5'b10000, 64'h1, 64'h2, "R9");
    send(1'b0, 5'b11000, 64'h1, 64'h2, "R9");
    send(1'b1, 5'b00010, 64'h1, 64'h2, "R9");
    send(1'b1, 5'b10000, 64'h1, 64'h2, "R9");
    send(1'b1, 5'b11000, 64'h1, 64'h2, "R9");
    // R10: word forms with differing upper halves give equal results
    send(1'b0, 5'd0,  64'h0000_0000_0F0F_1234, 64'h0000_0000_8421_00FF, "R10");
    send(1'b0, 5'd0,  64'hFFFF_FFFF_0F0F_1234, 64'hA5A5_A5A5_8421_00FF, "R10");
    send(1'b0, 5'd10, 64'h0000_0000_0F0F_1234, 64'h0000_0000_8421_00FF, "R10");
    send(1'b0, 5'd10, 64'hFFFF_FFFF_0F0F_1234, 64'hA5A5_A5A5_8421_00FF, "R10");
    idle(3);
    // Full sweep of the decode space with random operands
    for (int c = 0; c < 64; c++) begin
      send(1'(c / 32), 5'(c % 32), {$urandom, $urandom}, {$urandom, $urandom}, "");
      if (c % 7 == 3) idle(1);
    end
    // Random traffic with gaps
    for (int n = 0; n < 300; n++) begin
      send(1'($urandom), 5'($urandom % 16), {$urandom, $urandom}, {$urandom, $urandom}, "");
      if ($urandom % 4 == 0) idle(1 + $urandom % 2);
    end
    idle(3);
    check(q_data.size() == 0, "R2 all results delivered",
          65'(q_data.size()), 65'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule